// File: doc/BRIEF.md
# Daisy-Chained Bus Grant Arbiter

This block decides which of several devices may drive a shared data bus. A central arbiter watches a request line formed by ORing every device's request. When it sees a request on an idle bus, it raises a grant at the head of a chain of identical device slices. Each slice either absorbs the grant, when its own device is asking for the bus, or forwards it one clock later to the next slice. Position in the chain therefore sets priority: the slice nearest the arbiter wins.

The slice that absorbs the grant raises the common selection-acknowledge line. The arbiter answers by dropping the grant. The selected slice then waits until its incoming grant has fallen and nobody else holds bus busy. It then raises bus busy, and its device owns the bus. When the device reports completion, the slice drops busy and acknowledge together, and the arbiter may grant again. A grant that travels off the end of the chain unclaimed is withdrawn after a fixed number of clocks, and the request line is sampled again.

Top module: `bus_grant_chain`

## Requirements
- R1: While `arb_grant`, `sel_ack` and `bus_busy` are all low, any high bit of `dev_req` makes `arb_grant` go high on the next clock.
- R2: A slice whose device is not requesting forwards the grant with one clock of delay per slice. With the default four slices, `grant_tail` rises exactly 4 clocks after `arb_grant`.
- R3: A slice whose device is requesting when the grant reaches it blocks the grant and raises `sel_ack` on the next clock. No slice further down sees the grant.
- R4: The arbiter drops `arb_grant` on the clock after it samples `sel_ack` high.
- R5: A selected slice raises its busy only after its incoming grant is low and `bus_busy` is low. For slice k (0 = nearest the arbiter), `dev_own[k]` rises 2k+4 clock edges after `dev_req[k]` is raised on an idle bus. The count includes the first edge that samples the request.
- R6: When several devices request at once, the lowest-numbered slice gets the bus first. The others keep waiting and are served later.
- R7: On the clock after the owning device pulses its `dev_done` bit, `dev_own`, `bus_busy` and `sel_ack` are all low.
- R8: `arb_grant` never rises while `sel_ack` or `bus_busy` is high, so no request is granted while another device owns the bus.
- R9: If `arb_grant` has been high for 16 clocks with no `sel_ack`, it falls. If no request is present it stays low, and a later request is granted normally.
- R10: While `rst_n` is low, `arb_grant`, `grant_tail`, `sel_ack`, `bus_busy` and `dev_own` are all low.
- R11: At most one bit of `dev_own` is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_req | input | N_DEV | Per-device bus request, bit 0 nearest the arbiter |
| dev_done | input | N_DEV | Per-device one-clock pulse ending its ownership |
| dev_own | output | N_DEV | Per-device ownership of the data bus |
| arb_grant | output | 1 | Grant driven by the arbiter into the head of the chain |
| grant_tail | output | 1 | Grant leaving the last slice (unclaimed grant) |
| sel_ack | output | 1 | OR of all slices' selection acknowledge |
| bus_busy | output | 1 | OR of all slices' bus busy |

## Verification
The assertions assume that a device holds its request steady from the moment it raises it until it owns the bus. They also assume that a device pulses done only while it owns the bus and lowers its request in the same cycle. The directed stimulus follows both rules. It changes inputs only on falling edges and raises done only after `dev_own` has been observed. The unclaimed-grant case is made by a request that lasts a single clock, so it is withdrawn before the grant can reach its slice.

// File: rtl/bus_grant_pkg.sv
package bus_grant_pkg;

  typedef enum logic {
    ARB_IDLE  = 1'b0,
    ARB_GRANT = 1'b1
  } arb_state_t;

  typedef enum logic [1:0] {
    SL_IDLE = 2'd0,
    SL_SEL  = 2'd1,
    SL_OWN  = 2'd2
  } slice_state_t;

endpackage

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
  import bus_grant_pkg::*;
#(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req,
  input  logic sel_ack,
  input  logic bus_busy,
  output logic grant
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  arb_state_t     st_q, st_d;
  logic           grant_q, grant_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    st_d    = st_q;
    grant_d = grant_q;
    cnt_d   = cnt_q;
    case (st_q)
      ARB_IDLE: begin
        if (bus_req && !sel_ack && !bus_busy) begin
          st_d    = ARB_GRANT;
          grant_d = 1'b1;
          cnt_d   = '0;
        end
      end
      ARB_GRANT: begin
        if (sel_ack) begin
          st_d    = ARB_IDLE;
          grant_d = 1'b0;
        end else if (cnt_q == LAST) begin
          st_d    = ARB_IDLE;
          grant_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d    = ARB_IDLE;
        grant_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ARB_IDLE;
      grant_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      st_q    <= st_d;
      grant_q <= grant_d;
      cnt_q   <= cnt_d;
    end
  end

  assign grant = grant_q;

  // Independent watch of how long the grant has stayed high
  logic [CW-1:0] hold_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             hold_q <= '0;
    else if (!grant_q)                      hold_q <= '0;
    else if (hold_q != CW'(TIMEOUT))        hold_q <= hold_q + 1'b1;
  end

  p_grant_on_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_q && bus_req && !sel_ack && !bus_busy) |=> grant_q);

  p_drop_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q && sel_ack) |=> !grant_q);

  p_no_grant_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_q) |-> $past(!sel_ack && !bus_busy));

  p_grant_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_q |-> (hold_q < CW'(TIMEOUT)));

endmodule

// File: rtl/bus_grant_slice.sv
module bus_grant_slice
  import bus_grant_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dev_req,
  input  logic dev_done,
  input  logic grant_in,
  input  logic bus_busy_in,
  output logic grant_out,
  output logic sack,
  output logic bbsy
);

  slice_state_t st_q, st_d;
  logic         gout_q, gout_d;
  logic         sack_q, sack_d;
  logic         bbsy_q, bbsy_d;

  always_comb begin
    st_d   = st_q;
    gout_d = 1'b0;
    sack_d = sack_q;
    bbsy_d = bbsy_q;
    case (st_q)
      SL_IDLE: begin
        if (grant_in && dev_req) begin
          st_d   = SL_SEL;
          sack_d = 1'b1;
        end else begin
          gout_d = grant_in;
        end
      end
      SL_SEL: begin
        if (!grant_in && !bus_busy_in) begin
          st_d   = SL_OWN;
          bbsy_d = 1'b1;
        end
      end
      SL_OWN: begin
        if (dev_done) begin
          st_d   = SL_IDLE;
          sack_d = 1'b0;
          bbsy_d = 1'b0;
        end
      end
      default: begin
        st_d   = SL_IDLE;
        sack_d = 1'b0;
        bbsy_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SL_IDLE;
      gout_q <= 1'b0;
      sack_q <= 1'b0;
      bbsy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      gout_q <= gout_d;
      sack_q <= sack_d;
      bbsy_q <= bbsy_d;
    end
  end

  assign grant_out = gout_q;
  assign sack      = sack_q;
  assign bbsy      = bbsy_q;

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SL_IDLE && grant_in && !dev_req) |=> grant_out);

  p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SL_IDLE && grant_in && dev_req) |=> (sack && !grant_out));

  p_busy_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bbsy) |-> $past(!grant_in && !bus_busy_in));

  p_busy_has_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bbsy |-> sack);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SL_OWN && dev_done) |=> (!sack && !bbsy));

endmodule

// File: rtl/bus_grant_chain.sv
module bus_grant_chain #(
  parameter int N_DEV   = 4,
  parameter int TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] dev_req,
  input  logic [N_DEV-1:0] dev_done,
  output logic [N_DEV-1:0] dev_own,
  output logic             arb_grant,
  output logic             grant_tail,
  output logic             sel_ack,
  output logic             bus_busy
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [N_DEV:0]   gchain;
  logic [N_DEV-1:0] sack_v;
  logic [N_DEV-1:0] bbsy_v;
  logic             req_or;

  assign req_or   = |dev_req;
  assign sel_ack  = |sack_v;
  assign bus_busy = |bbsy_v;

  bus_grant_arbiter #(.TIMEOUT(TIMEOUT)) u_arb (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .bus_req  (req_or),
    .sel_ack  (sel_ack),
    .bus_busy (bus_busy),
    .grant    (gchain[0])
  );

  for (genvar i = 0; i < N_DEV; i++) begin : g_slice
    bus_grant_slice u_slice (
      .clk         (clk),
      .rst_n       (rst_sync_q),
      .dev_req     (dev_req[i]),
      .dev_done    (dev_done[i]),
      .grant_in    (gchain[i]),
      .bus_busy_in (bus_busy),
      .grant_out   (gchain[i+1]),
      .sack        (sack_v[i]),
      .bbsy        (bbsy_v[i])
    );
  end

  assign arb_grant  = gchain[0];
  assign grant_tail = gchain[N_DEV];
  assign dev_own    = bbsy_v;

  p_one_owner_r11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(bbsy_v));

  p_one_selected_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(sack_v));

endmodule

// File: tb/bus_grant_chain_test.sv
module bus_grant_chain_test;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] dev_req;
  logic [N-1:0] dev_done;
  logic [N-1:0] dev_own;
  logic         arb_grant, grant_tail, sel_ack, bus_busy;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bus_grant_chain #(.N_DEV(N), .TIMEOUT(16)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_req    (dev_req),
    .dev_done   (dev_done),
    .dev_own    (dev_own),
    .arb_grant  (arb_grant),
    .grant_tail (grant_tail),
    .sel_ack    (sel_ack),
    .bus_busy   (bus_busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n    = 1'b0;
    dev_req  = '0;
    dev_done = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({arb_grant, grant_tail, sel_ack, bus_busy, dev_own} == '0, "R10 reset outputs",
        int'({arb_grant, grant_tail, sel_ack, bus_busy, dev_own}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Release ownership of slice k and confirm the bus is free next clock
  task automatic release_dev(input int k);
    dev_done[k] = 1'b1;
    dev_req[k]  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    dev_done[k] = 1'b0;
    chk(dev_own == '0 && !bus_busy && !sel_ack, "R7 release",
        int'({dev_own, bus_busy, sel_ack}), 0);
  endtask

  task automatic t_single(input int k);
    int n = 0;
    bit tail_seen = 0;
    @(negedge clk);
    dev_req[k] = 1'b1;
    while (n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (grant_tail) tail_seen = 1;
      if (n == 1) chk(arb_grant, "R1 grant after request", int'(arb_grant), 1);
      if (dev_own[k]) break;
    end
    chk(n == 2*k + 4, "R5 ownership latency", n, 2*k + 4);
    chk(dev_own == N'(1) << k, "R11 sole owner", int'(dev_own), int'(N'(1) << k));
    chk(!arb_grant && sel_ack && bus_busy, "R4 grant dropped while owned",
        int'({arb_grant, sel_ack, bus_busy}), 3);
    chk(!tail_seen, "R3 grant blocked by requester", int'(tail_seen), 0);
    release_dev(k);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_priority();
    int n = 0;
    @(negedge clk);
    dev_req[0] = 1'b1;
    dev_req[2] = 1'b1;
    while (n < 40 && !dev_own[0]) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk(n == 4 && dev_own == 4'b0001, "R6 nearest slice wins", int'(dev_own), 1);
    dev_done[0] = 1'b1;
    dev_req[0]  = 1'b0;
    n = 0;
    while (n < 40) begin
      @(posedge clk); n++; @(negedge clk);
      dev_done[0] = 1'b0;
      if (dev_own[2]) break;
    end
    chk(n == 9, "R6 waiting slice served after release", n, 9);
    release_dev(2);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_hold_off();
    int n = 0;
    bit granted = 0;
    @(negedge clk);
    dev_req[1] = 1'b1;
    while (n < 40 && !dev_own[1]) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk(dev_own[1], "R5 slice 1 owns", int'(dev_own), 2);
    dev_req[0] = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (arb_grant || dev_own[0]) granted = 1;
    end
    chk(!granted, "R8 no grant while bus owned", int'(granted), 0);
    dev_done[1] = 1'b1;
    dev_req[1]  = 1'b0;
    n = 0;
    while (n < 40) begin
      @(posedge clk); n++; @(negedge clk);
      dev_done[1] = 1'b0;
      if (dev_own[0]) break;
    end
    chk(n == 5, "R8 grant after bus freed", n, 5);
    release_dev(0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_timeout();
    int idx = 0;
    int first_g = -1;
    int first_t = -1;
    int high = 0;
    bit late = 0;
    @(negedge clk);
    dev_req[3] = 1'b1;
    @(negedge clk);
    dev_req[3] = 1'b0;
    idx = 1;
    while (idx < 60) begin
      if (arb_grant) begin
        high++;
        if (first_g < 0) first_g = idx;
      end
      if (grant_tail && first_t < 0) first_t = idx;
      if (first_g >= 0 && !arb_grant) break;
      @(negedge clk);
      idx++;
    end
    chk(first_t - first_g == N, "R2 grant ripple delay", first_t - first_g, N);
    chk(high == 16, "R9 unclaimed grant withdrawn", high, 16);
    chk(dev_own == '0 && !sel_ack, "R9 no owner after timeout", int'(dev_own), 0);
    repeat (8) begin
      @(negedge clk);
      if (arb_grant) late = 1;
    end
    chk(!late, "R9 no regrant without request", int'(late), 0);
  endtask

  initial begin
    t_reset();
    for (int k = 0; k < N; k++) t_single(k);
    t_priority();
    t_hold_off();
    t_timeout();
    t_single(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule